// File: doc/BRIEF.md
# Relative-Branch Program Counter

This block keeps the instruction index for a small microcoded processor. Each clock edge it does one of three things: it keeps its value, it advances by one, or it adds a short signed displacement. The sequencer drives two control lines, one to advance and one to take a relative jump. The two 3-bit register-select fields of the current instruction form the displacement. The registered value goes to the memory address selector.

Whether a branch is taken is decided in the sequencer; this block only applies the jump when told to. The displacement is joined from the two fields, with the first field in the upper half. It is then sign-extended to the counter width, so the counter can move backward or forward. All arithmetic wraps at the counter width.

Top module: `rel_branch_pc`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` becomes 0 (reset value) on that edge, whatever the other inputs are; the reset is synchronous and active-high.
- R2: With `rst` low, `inc_i` high and `rel_i` low at a rising edge, `pc_o` becomes its previous value plus one.
- R3: With `rst` low and `rel_i` high, `pc_o` becomes its previous value plus the displacement {`src_a_i`, `src_b_i`}. `src_a_i` supplies bits 5..3 and `src_b_i` supplies bits 2..0, so a=1, b=0 means +8.
- R4: The 6-bit displacement is two's complement and is sign-extended from bit 5, covering -32 to +31. For example, a=3'b100, b=3'b000 moves back 32, and a=b=3'b111 moves back 1.
- R5: When `inc_i` and `rel_i` are both high, the relative jump is applied and the increment is not.
- R6: With `inc_i` and `rel_i` both low, `pc_o` keeps its value, and changes on `src_a_i`/`src_b_i` have no effect on it.
- R7: `pc_o` wraps modulo 2^16. 0xFFFF plus one gives 0, and 0 plus -1 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | 1 | Advance the counter by one |
| rel_i | input | 1 | Add the sign-extended displacement (wins over `inc_i`) |
| src_a_i | input | FIELD_W (3) | Upper half of the displacement |
| src_b_i | input | FIELD_W (3) | Lower half of the displacement |
| pc_o | output | PC_W (16) | Registered counter value |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and 3-bit fields, giving a 6-bit displacement. At this width, one backward jump of 1 from zero reaches 0xFFFF, so both directions of wraparound are exercised directly. The extreme displacements +31 and -32 are tested. The field order is pinned by asymmetric values such as +8 against +1. A mixed run of holds, steps and jumps is checked against an independent model.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_STEP = 2'd1,
    PC_JUMP = 2'd2
  } pc_op_e;

  // Relative jump has priority over increment.
  function automatic pc_op_e pick_op(input logic inc, input logic rel);
    if (rel)      return PC_JUMP;
    else if (inc) return PC_STEP;
    else          return PC_HOLD;
  endfunction

endpackage

// File: rtl/pcb_offset_ext.sv
module pcb_offset_ext #(
  parameter int PC_W    = 16,
  parameter int FIELD_W = 3
) (
  input  logic [FIELD_W-1:0] hi_i,
  input  logic [FIELD_W-1:0] lo_i,
  output logic [PC_W-1:0]    disp_o
);
  localparam int OFF_W = 2 * FIELD_W;

  logic [OFF_W-1:0] raw;
  assign raw = {hi_i, lo_i};

  generate
    if (OFF_W < PC_W) begin : g_ext
      assign disp_o = {{(PC_W-OFF_W){raw[OFF_W-1]}}, raw};
    end else begin : g_trunc
      assign disp_o = raw[PC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pcb_next_sel.sv
module pcb_next_sel
  import pcb_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  pc_op_e          op_i,
  input  logic [PC_W-1:0] cur_i,
  input  logic [PC_W-1:0] disp_i,
  output logic [PC_W-1:0] nxt_o
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  always_comb begin
    unique case (op_i)
      PC_STEP: nxt_o = cur_i + ONE;
      PC_JUMP: nxt_o = cur_i + disp_i;
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/pcb_count_reg.sv
module pcb_count_reg #(
  parameter int PC_W = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] d_i,
  output logic [PC_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= RESET_PC;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/rel_branch_pc.sv
module rel_branch_pc
  import pcb_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc_i,
  input  logic               rel_i,
  input  logic [FIELD_W-1:0] src_a_i,
  input  logic [FIELD_W-1:0] src_b_i,
  output logic [PC_W-1:0]    pc_o
);
  pc_op_e          op;
  logic [PC_W-1:0] disp;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;

  assign op = pick_op(inc_i, rel_i);

  pcb_offset_ext #(.PC_W(PC_W), .FIELD_W(FIELD_W)) u_ext (
    .hi_i  (src_a_i),
    .lo_i  (src_b_i),
    .disp_o(disp)
  );

  pcb_next_sel #(.PC_W(PC_W)) u_sel (
    .op_i  (op),
    .cur_i (pc_q),
    .disp_i(disp),
    .nxt_o (pc_d)
  );

  pcb_count_reg #(.PC_W(PC_W), .RESET_PC('0)) u_reg (
    .clk(clk),
    .rst(rst),
    .d_i(pc_d),
    .q_o(pc_q)
  );

  assign pc_o = pc_q;
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int PC_W    = 16,
  parameter int FIELD_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               inc_i,
  input logic               rel_i,
  input logic [FIELD_W-1:0] src_a_i,
  input logic [FIELD_W-1:0] src_b_i,
  input logic [PC_W-1:0]    pc_o
);
  localparam int OFF_W = 2 * FIELD_W;

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  function automatic logic [PC_W-1:0] sext(input logic [OFF_W-1:0] v);
    return {{(PC_W-OFF_W){v[OFF_W-1]}}, v};
  endfunction

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> pc_o == '0);

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (inc_i && !rel_i) |=> pc_o == $past(pc_o) + PC_W'(1));

  // R3
  jump_add_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    rel_i |=> pc_o == $past(pc_o) + sext($past({src_a_i, src_b_i})));

  // R5
  jump_wins_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (rel_i && inc_i) |=> pc_o != $past(pc_o) + PC_W'(1)
                         || $past({src_a_i, src_b_i}) == OFF_W'(1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (!inc_i && !rel_i) |=> $stable(pc_o));
endmodule

bind rel_branch_pc pcb_checker #(.PC_W(PC_W), .FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst(rst), .inc_i(inc_i), .rel_i(rel_i),
  .src_a_i(src_a_i), .src_b_i(src_b_i), .pc_o(pc_o)
);

// File: tb/test_rel_branch_pc.sv
`timescale 1ns/1ps
module test_rel_branch_pc;
  localparam int PC_W = 16;
  localparam int FW   = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inc = 1'b0;
  logic          rel = 1'b0;
  logic [FW-1:0] fa  = '0;
  logic [FW-1:0] fb  = '0;
  logic [PC_W-1:0] pc;

  always #10 clk = ~clk;

  rel_branch_pc #(.PC_W(PC_W), .FIELD_W(FW)) i_rel_branch_pc (
    .clk(clk), .rst(rst), .inc_i(inc), .rel_i(rel),
    .src_a_i(fa), .src_b_i(fb), .pc_o(pc)
  );

  logic [PC_W-1:0] exp_q[$];
  string           tag_q[$];
  logic [PC_W-1:0] model = '0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Driver: inputs change at the falling edge; expectation pushed then.
  task automatic drive(input bit r, input bit i, input bit l,
                       input logic [FW-1:0] a, input logic [FW-1:0] b,
                       input string tag);
    logic [2*FW-1:0] off;
    @(negedge clk);
    rst = r; inc = i; rel = l; fa = a; fb = b;
    off = {a, b};
    if (r)      model = '0;
    else if (l) model = model + {{(PC_W-2*FW){off[2*FW-1]}}, off};
    else if (i) model = model + 1'b1;
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares 5 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [PC_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (pc !== e) begin
          n_bad++;
          $display("FAIL %s: pc=%h expected %h", t, pc, e);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end (expected completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    drive(1, 1, 1, 3'b011, 3'b111, "R1");
    drive(1, 0, 0, 0, 0, "R1");
    // R2 steps
    drive(0, 1, 0, 0, 0, "R2");
    drive(0, 1, 0, 3'b101, 3'b010, "R2");
    drive(0, 1, 0, 0, 0, "R2");
    // R6 hold with wiggling fields
    drive(0, 0, 0, 3'b111, 3'b111, "R6");
    drive(0, 0, 0, 3'b010, 3'b001, "R6");
    // R3 field order and max forward
    drive(0, 0, 1, 3'b001, 3'b000, "R3");
    drive(0, 0, 1, 3'b000, 3'b001, "R3");
    drive(0, 0, 1, 3'b011, 3'b111, "R3");
    // R4 backward
    drive(0, 0, 1, 3'b111, 3'b111, "R4");
    drive(0, 0, 1, 3'b100, 3'b000, "R4");
    drive(0, 0, 1, 3'b111, 3'b011, "R4");
    // R5 priority
    drive(0, 1, 1, 3'b000, 3'b101, "R5");
    drive(0, 1, 1, 3'b110, 3'b000, "R5");
    // R1 reset overrides active controls
    drive(1, 1, 0, 0, 0, "R1");
    // R7 wrap both ways
    drive(0, 0, 1, 3'b111, 3'b111, "R7");
    drive(0, 1, 0, 0, 0, "R7");
    drive(0, 0, 1, 3'b111, 3'b110, "R7");
    drive(0, 0, 1, 3'b000, 3'b011, "R7");
    // Mixed run
    for (int k = 0; k < 60; k++) begin
      logic [FW-1:0] a;
      logic [FW-1:0] b;
      bit i;
      bit l;
      a = FW'($urandom);
      b = FW'($urandom);
      i = 1'($urandom);
      l = 1'($urandom);
      drive(0, i, l, a, b, l ? "R3" : (i ? "R2" : "R6"));
    end
    @(negedge clk);
    inc = 0; rel = 0;
    @(posedge clk); #6;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule